// File: doc/BRIEF.md
# PWM Duty Demand Decoder

This block turns an external pulse-width-modulated speed command into a 9-bit demand code and a run-enable flag. The command pin is brought into the clock domain, cleaned of short noise pulses and then timed. Each high time is counted and each period is taken from one rising edge to the next, all in system clock cycles. A short sequential divider then scales the ratio of the two counts so that a duty of 100% lands on the top code.

The enable flag has a hysteresis band. It switches on once the demand reaches about 10% of full scale. It switches off only when the demand falls below about 7.5%. A pin that stops toggling is detected with an idle timeout, which is set longer than the slowest legal input period. When the timeout expires, the demand is forced to zero if the pin is held low and to full scale if it is held high. Every new demand value is marked by a one-cycle valid strobe.

Top module: `spd_duty_decoder`

## Requirements
- R1: While reset is asserted and directly after it, `demand` is 0, `demand_valid` is 0 and `run_en` is 0.
- R2: For a clean input whose rising edges are P cycles apart with H high cycles in between, each measured period yields `demand` = floor(H × 511 / P). `demand` and `run_en` change only in a cycle where `demand_valid` is 1.
- R3: `demand_valid` is a single-cycle pulse. There is one pulse for each measured period and one for each expired timeout window.
- R4: With `run_en` at 0, a new demand of 51 or more sets `run_en`. A new demand of 50 or less leaves it at 0.
- R5: With `run_en` at 1, a new demand below 39 clears `run_en`. A new demand of 39 or more leaves it at 1.
- R6: The input passes a two-stage synchroniser and a 3-sample majority vote. An input pulse one clock long does not count as an edge, so it produces no strobe and does not change `run_en`.
- R7: An input held high with no filtered edge for TIMEOUT_CYC cycles yields `demand` = 511 with a strobe, and `run_en` becomes 1.
- R8: An input held low with no filtered edge for TIMEOUT_CYC cycles yields `demand` = 0 with a strobe, and `run_en` becomes 0.
- R9: After a timeout, the first rising edge only starts a new measurement and gives no strobe. The next rising edge gives a correct demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Asynchronous PWM speed command |
| demand | output | 9 | Latest demand code, 0 to 511 |
| demand_valid | output | 1 | One-cycle strobe marking a new demand |
| run_en | output | 1 | Run enable with on/off hysteresis |

## Verification
The hardest state to reach from the pins is the first rising edge after an idle timeout, because the period counter then holds a span that is not a real period. The stimulus holds the pin low past the timeout and then restarts a known waveform. It expects exactly one strobe from the first two rising edges, and that strobe must carry the exact code. The hysteresis band is walked edge by edge with duty steps that give codes 40, 39, 38, 50 and 51. Single-cycle spikes are injected on a held-low pin, inside a window shorter than the timeout, to show that no strobe appears.

// File: rtl/spd_duty_pkg.sv
package spd_duty_pkg;

   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

   function automatic logic vote3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
   endfunction

endpackage

// File: rtl/spd_in_cond.sv
module spd_in_cond #(
   parameter int SYNC_STAGES = 2,
   parameter bit FILT_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic lvl,
   output logic rise,
   output logic fall
);
   import spd_duty_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   clean_d;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
   end

   if (FILT_EN) begin : g_vote
      logic [2:0] win_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win_q <= '0;
         else        win_q <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
      end
      assign clean_d = vote3(win_q);
   end else begin : g_plain
      assign clean_d = sync_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= clean_d;
   end

   assign lvl  = clean_d;
   assign rise = clean_d & ~lvl_q;
   assign fall = ~clean_d & lvl_q;
endmodule

// File: rtl/spd_period_meter.sv
module spd_period_meter #(
   parameter int CNT_W       = 20,
   parameter int TIMEOUT_CYC = 600000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             rise,
   input  logic             fall,
   output logic [CNT_W-1:0] hi_len,
   output logic [CNT_W-1:0] per_len,
   output logic             meas_stb,
   output logic             stuck_stb,
   output logic             stuck_lvl
);
   if (TIMEOUT_CYC < 2 || TIMEOUT_CYC >= (2 ** CNT_W)) begin : g_bad_to
      $error("TIMEOUT_CYC must fit in CNT_W bits");
   end

   localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic [CNT_W-1:0] per_cnt, hi_cnt, idle_cnt;
   logic             primed;
   logic             edge_seen, idle_hit;

   assign edge_seen = rise | fall;
   assign idle_hit  = !edge_seen && (idle_cnt == IDLE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt  <= '0;
         stuck_stb <= 1'b0;
         stuck_lvl <= 1'b0;
      end else begin
         stuck_stb <= idle_hit;
         if (edge_seen || idle_hit) idle_cnt <= '0;
         else                       idle_cnt <= idle_cnt + 1'b1;
         if (idle_hit) stuck_lvl <= lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt  <= '0;
         hi_cnt   <= '0;
         hi_len   <= '0;
         per_len  <= '0;
         meas_stb <= 1'b0;
         primed   <= 1'b0;
      end else begin
         meas_stb <= 1'b0;
         if (rise) begin
            if (primed) begin
               hi_len   <= hi_cnt;
               per_len  <= per_cnt;
               meas_stb <= 1'b1;
            end
            primed  <= 1'b1;
            per_cnt <= CNT_W'(1);
            hi_cnt  <= CNT_W'(1);
         end else begin
            if (idle_hit) primed <= 1'b0;
            if (per_cnt != CNT_MAX) per_cnt <= per_cnt + 1'b1;
            if (lvl && hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spd_ratio_div.sv
module spd_ratio_div #(
   parameter int CNT_W     = 20,
   parameter int DEM_W     = 9,
   parameter int FULL_CODE = 511
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] hi_len,
   input  logic [CNT_W-1:0] per_len,
   output logic             busy,
   output logic             done,
   output logic [DEM_W-1:0] quo
);
   import spd_duty_pkg::*;

   if (DEM_W < 2 || FULL_CODE >= (2 ** DEM_W) || FULL_CODE < 1) begin : g_bad_code
      $error("FULL_CODE must fit in DEM_W bits");
   end

   localparam int NUM_W  = CNT_W + DEM_W;
   localparam int STEP_W = $clog2(DEM_W);

   div_state_e        state_q;
   logic [NUM_W-1:0]  rem_q, dsh_q;
   logic [DEM_W-1:0]  q_q, q_next;
   logic [STEP_W-1:0] step_q;
   logic              take;

   assign take   = (rem_q >= dsh_q);
   assign q_next = {q_q[DEM_W-2:0], take};
   assign busy   = (state_q == DIV_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DIV_IDLE;
         rem_q   <= '0;
         dsh_q   <= '0;
         q_q     <= '0;
         step_q  <= '0;
         done    <= 1'b0;
         quo     <= '0;
      end else begin
         done <= 1'b0;
         case (state_q)
            DIV_IDLE: if (start) begin
               rem_q   <= NUM_W'(hi_len) * NUM_W'(FULL_CODE);
               dsh_q   <= NUM_W'(per_len) << (DEM_W - 1);
               q_q     <= '0;
               step_q  <= STEP_W'(DEM_W - 1);
               state_q <= DIV_RUN;
            end
            DIV_RUN: begin
               if (take) rem_q <= rem_q - dsh_q;
               dsh_q <= dsh_q >> 1;
               q_q   <= q_next;
               if (step_q == '0) begin
                  quo     <= q_next;
                  done    <= 1'b1;
                  state_q <= DIV_IDLE;
               end else begin
                  step_q <= step_q - 1'b1;
               end
            end
            default: state_q <= DIV_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spd_duty_decoder.sv
module spd_duty_decoder #(
   parameter int CNT_W       = 20,
   parameter int TIMEOUT_CYC = 600000,
   parameter int DEM_W       = 9,
   parameter int FULL_CODE   = 511,
   parameter int ON_CODE     = 51,
   parameter int OFF_CODE    = 39,
   parameter int SYNC_STAGES = 2,
   parameter bit FILT_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   output logic [DEM_W-1:0] demand,
   output logic             demand_valid,
   output logic             run_en
);
   if (OFF_CODE > ON_CODE || ON_CODE > FULL_CODE) begin : g_bad_hyst
      $error("need OFF_CODE <= ON_CODE <= FULL_CODE");
   end
   if (TIMEOUT_CYC <= 4 * DEM_W) begin : g_bad_short
      $error("TIMEOUT_CYC too short for the divider");
   end

   localparam logic [DEM_W-1:0] FULL_C = DEM_W'(FULL_CODE);
   localparam logic [DEM_W-1:0] ON_C   = DEM_W'(ON_CODE);
   localparam logic [DEM_W-1:0] OFF_C  = DEM_W'(OFF_CODE);

   logic             lvl, rise, fall;
   logic [CNT_W-1:0] hi_len, per_len;
   logic             meas_stb, stuck_stb, stuck_lvl;
   logic             div_busy, div_done;
   logic [DEM_W-1:0] quo, new_code;
   logic             upd;

   spd_in_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_EN(FILT_EN)) u_cond (
      .clk(clk), .rst_n(rst_n), .raw_in(pwm_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   spd_period_meter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall),
      .hi_len(hi_len), .per_len(per_len), .meas_stb(meas_stb),
      .stuck_stb(stuck_stb), .stuck_lvl(stuck_lvl)
   );

   spd_ratio_div #(.CNT_W(CNT_W), .DEM_W(DEM_W), .FULL_CODE(FULL_CODE)) u_div (
      .clk(clk), .rst_n(rst_n), .start(meas_stb && !div_busy),
      .hi_len(hi_len), .per_len(per_len),
      .busy(div_busy), .done(div_done), .quo(quo)
   );

   always_comb begin
      upd      = stuck_stb | div_done;
      new_code = stuck_stb ? (stuck_lvl ? FULL_C : '0) : quo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         demand       <= '0;
         demand_valid <= 1'b0;
         run_en       <= 1'b0;
      end else begin
         demand_valid <= upd;
         if (upd) begin
            demand <= new_code;
            if (!run_en && new_code >= ON_C)     run_en <= 1'b1;
            else if (run_en && new_code < OFF_C) run_en <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spd_duty_chk.sv
module spd_duty_chk #(
   parameter int DEM_W    = 9,
   parameter int ON_CODE  = 51,
   parameter int OFF_CODE = 39
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DEM_W-1:0] demand,
   input logic             demand_valid,
   input logic             run_en
);
   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      demand_valid |=> !demand_valid);

   // R2
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !demand_valid |-> ($stable(demand) && $stable(run_en)));

   // R4
   enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> (demand_valid && demand >= DEM_W'(ON_CODE)));

   // R5
   enable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_en) |-> (demand_valid && demand < DEM_W'(OFF_CODE)));
endmodule

bind spd_duty_decoder spd_duty_chk #(
   .DEM_W(DEM_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .demand(demand),
   .demand_valid(demand_valid), .run_en(run_en)
);

// File: tb/sim_spd_duty_decoder.sv
module sim_spd_duty_decoder;
   localparam int TO_CYC = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_in = 1'b0;
   logic [8:0] demand;
   logic       demand_valid;
   logic       run_en;

   int vectors = 0;
   int errors = 0;
   int nvalid = 0;
   int last_dem = 0;

   always #10 clk = ~clk;

   spd_duty_decoder #(.CNT_W(14), .TIMEOUT_CYC(TO_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
      .demand(demand), .demand_valid(demand_valid), .run_en(run_en)
   );

   always @(negedge clk) begin
      if (demand_valid) begin
         nvalid   <= nvalid + 1;
         last_dem <= int'(demand);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int code_of(input int hi, input int per);
      return (hi * 511) / per;
   endfunction

   task automatic drive(input int per, input int hi, input int n);
      for (int i = 0; i < n; i++) begin
         pwm_in = 1'b1;
         repeat (hi) @(negedge clk);
         pwm_in = 1'b0;
         repeat (per - hi) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 demand", int'(demand), 0);
      check("R1 valid", int'(demand_valid), 0);
      check("R1 run_en", int'(run_en), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 demand after release", int'(demand), 0);
   endtask

   task automatic t_duty_steps();
      drive(200, 100, 4);
      check("R2 50% code", last_dem, code_of(100, 200));
      check("R4 on at 255", int'(run_en), 1);
      drive(400, 100, 4);
      check("R2 25% code", last_dem, 127);
      drive(2500, 625, 3);
      check("R2 long period code", last_dem, code_of(625, 2500));
   endtask

   task automatic t_count_strobes();
      int v0;
      v0 = nvalid;
      drive(300, 90, 5);
      check("R3 strobes per period", nvalid - v0, 5);
      check("R2 30% code", last_dem, code_of(90, 300));
   endtask

   task automatic t_hysteresis();
      drive(1000, 80, 3);
      check("R5 code 40", last_dem, 40);
      check("R5 holds on at 40", int'(run_en), 1);
      drive(1000, 77, 3);
      check("R5 code 39", last_dem, 39);
      check("R5 holds on at 39", int'(run_en), 1);
      drive(1000, 76, 3);
      check("R5 code 38", last_dem, 38);
      check("R5 off below 39", int'(run_en), 0);
      drive(1000, 80, 3);
      check("R4 stays off at 40", int'(run_en), 0);
      drive(1000, 98, 3);
      check("R4 code 50", last_dem, 50);
      check("R4 stays off at 50", int'(run_en), 0);
      drive(1000, 100, 3);
      check("R4 code 51", last_dem, 51);
      check("R4 on at 51", int'(run_en), 1);
   endtask

   task automatic t_stuck_high();
      drive(1000, 30, 2);
      pwm_in = 1'b1;
      repeat (TO_CYC + 400) @(negedge clk);
      check("R7 full code", last_dem, 511);
      check("R7 run on", int'(run_en), 1);
   endtask

   task automatic t_stuck_low_resume();
      int v0;
      pwm_in = 1'b0;
      repeat (TO_CYC + 400) @(negedge clk);
      check("R8 zero code", last_dem, 0);
      check("R8 run off", int'(run_en), 0);
      v0 = nvalid;
      drive(400, 100, 2);
      check("R9 one strobe after restart", nvalid - v0, 1);
      check("R9 first code", last_dem, 127);
   endtask

   task automatic t_glitch();
      int v0;
      pwm_in = 1'b0;
      repeat (TO_CYC + 400) @(negedge clk);
      check("R8 zero before spikes", int'(run_en), 0);
      v0 = nvalid;
      for (int k = 0; k < 20; k++) begin
         pwm_in = 1'b1;
         @(negedge clk);
         pwm_in = 1'b0;
         repeat (50) @(negedge clk);
      end
      check("R6 no strobe from spikes", nvalid - v0, 0);
      check("R6 run stays off", int'(run_en), 0);
      check("R6 demand stays 0", int'(demand), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_duty_steps();
      t_count_strobes();
      t_hysteresis();
      t_stuck_high();
      t_stuck_low_resume();
      t_glitch();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule